// File: doc/BRIEF.md
# Flash block health tracker

This block keeps the health state of every erase block in a small NAND array. Each block has a bad flag and a remaining-erase (wear) counter. The command sequencer asks the block whether a block index is usable before it reads, programs or erases. After each erase it sends a notify strobe, and the block's wear counter is decremented.

An initialisation pass loads a configured wear limit into every counter and clears every bad flag. It then takes a streamed list of bad block indices over a valid/ready channel. The list ends at a sentinel word, after a fixed maximum number of marks, or at an out-of-range index, which also raises an error flag. While this pass runs, the query and erase channels hold their ready low.

Back-pressure rules are the same for every channel. A transfer happens on a rising clock edge where valid and ready are both high. The sender holds valid and its payload steady until that edge. Ready never depends on valid.

Top module: `flash_block_health`

## Requirements
- R1: After reset every block reads as unusable (wear counter zero, bad flag clear). `busy`, `init_error` and `rsp_valid` are low.
- R2: A pulse on `init_start` while not busy does the following:
  - In the next cycle, every wear counter is loaded with the limit sampled from `init_wear` with the start, and every bad flag is cleared.
  - `busy` is high from the cycle after the start until the list phase ends.
  - A start while busy is ignored.
- R3: A sampled limit of zero means unlimited. It is stored as the all-ones value, and an erase never decrements an all-ones counter.
- R4: The list phase works as follows:
  - `bb_ready` is high one cycle after the counters are loaded.
  - Each accepted `bb_index` below the block count marks that block bad.
  - The word 0xFFFFFFFF ends the list without marking anything.
- R5: After MAX_BAD entries have marked blocks, the list phase ends by itself: `bb_ready` and `busy` drop and any further entries are never consumed.
- R6: An accepted list index, other than the sentinel, that is at or above the block count ends initialisation and sets `init_error`. Blocks marked before it stay bad. The flag stays set until the next accepted `init_start`, which clears it.
- R7: Queries are handled as follows:
  - `q_ready` and `er_ready` are low exactly while busy.
  - An accepted query gives `rsp_valid` high for one cycle on the next cycle.
  - `rsp_ok` is high only when the block is not bad and its wear counter is non-zero.
  - The answer reflects the state before any erase accepted on the same edge.
- R8: A query for an index at or above the block count answers `rsp_ok` low.
- R9: An accepted erase of an in-range block decrements its wear counter when the counter is neither zero nor all-ones. A counter at zero stays at zero. Bad blocks are decremented like any other. Out-of-range erase indices change nothing.
- R10: The block count is BLOCKS_PER_LUN times NUM_LUNS. With the defaults (8 and 2), index 15 is the last tracked block and 16 is out of range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| init_start | input | 1 | Starts an initialisation pass |
| init_wear | input | WEAR_W | Wear limit, sampled with init_start; zero means unlimited |
| bb_valid | input | 1 | Bad-list entry valid |
| bb_ready | output | 1 | Bad-list entry accepted |
| bb_index | input | 32 | Bad block index or 0xFFFFFFFF sentinel |
| busy | output | 1 | Initialisation in progress |
| init_error | output | 1 | Last initialisation hit an out-of-range index |
| q_valid | input | 1 | Validity query valid |
| q_ready | output | 1 | Query accepted |
| q_block | input | BLK_W | Queried block index |
| rsp_valid | output | 1 | Query answer valid |
| rsp_ok | output | 1 | Queried block is usable |
| er_valid | input | 1 | Erase notify valid |
| er_ready | output | 1 | Erase notify accepted |
| er_block | input | BLK_W | Erased block index |

## Verification
The wear counters and bad flags can only be seen through query answers, so a wrong internal state shows as a wrong `rsp_ok` one cycle after the next query that touches the block. The bench compares every output on every cycle against a behavioural model. This makes a counter that wraps below zero, decrements an unlimited value or loses a bad mark show up in the first query after the faulty erase or list entry. A handshake fault (wrong `busy`, `bb_ready` or ready timing) shows up in the same cycle it occurs.

// File: rtl/fbh_pkg.sv
package fbh_pkg;
  typedef enum logic [1:0] {
    LD_IDLE = 2'd0,
    LD_FILL = 2'd1,
    LD_LIST = 2'd2
  } ld_state_e;
endpackage

// File: rtl/fbh_cell.sv
module fbh_cell #(
  parameter int WEAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [WEAR_W-1:0] load_wear,
  input  logic              mark_en,
  input  logic              erase_en,
  output logic              usable
);
  localparam logic [WEAR_W-1:0] UNLIM = {WEAR_W{1'b1}};

  logic              bad_q;
  logic [WEAR_W-1:0] wear_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bad_q  <= 1'b0;
      wear_q <= '0;
    end else if (load_en) begin
      bad_q  <= 1'b0;
      wear_q <= load_wear;
    end else begin
      if (mark_en) bad_q <= 1'b1;
      if (erase_en && (wear_q != '0) && (wear_q != UNLIM))
        wear_q <= wear_q - 1'b1;
    end
  end

  assign usable = !bad_q && (wear_q != '0);

  // R3: an unlimited counter stays unlimited until the next load
  assert_unlimited_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && wear_q == UNLIM) |=> (wear_q == UNLIM));
  // R9: an exhausted counter never wraps
  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && wear_q == '0) |=> (wear_q == '0));
  // R4: a bad mark is kept until the next load
  assert_bad_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && bad_q) |=> bad_q);
endmodule

// File: rtl/fbh_loader.sv
module fbh_loader
  import fbh_pkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  parameter int WEAR_W     = 8,
  parameter int LIST_W     = 32,
  parameter int MAX_BAD    = 4,
  localparam int BIDX_W    = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
  localparam int CNT_W     = $clog2(MAX_BAD + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_start,
  input  logic [WEAR_W-1:0] init_wear,
  input  logic              bb_valid,
  output logic              bb_ready,
  input  logic [LIST_W-1:0] bb_index,
  output logic              busy,
  output logic              init_error,
  output logic              load_en,
  output logic [WEAR_W-1:0] load_wear,
  output logic              mark_en,
  output logic [BIDX_W-1:0] mark_idx
);
  localparam logic [LIST_W-1:0] SENTINEL = {LIST_W{1'b1}};
  localparam logic [LIST_W-1:0] NB_L     = LIST_W'(NUM_BLOCKS);
  localparam logic [CNT_W-1:0]  LAST_CNT = CNT_W'(MAX_BAD - 1);

  ld_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              err_q;
  logic [WEAR_W-1:0] wear_q;
  logic              take, is_end, is_oob;

  assign busy      = (state_q != LD_IDLE);
  assign bb_ready  = (state_q == LD_LIST);
  assign load_en   = (state_q == LD_FILL);
  assign load_wear = wear_q;
  assign take      = bb_valid && bb_ready;
  assign is_end    = (bb_index == SENTINEL);
  assign is_oob    = !is_end && (bb_index >= NB_L);
  assign mark_en   = take && !is_end && !is_oob;
  assign mark_idx  = bb_index[BIDX_W-1:0];
  assign init_error = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= LD_IDLE;
      cnt_q   <= '0;
      err_q   <= 1'b0;
      wear_q  <= '0;
    end else begin
      unique case (state_q)
        LD_IDLE: if (init_start) begin
          state_q <= LD_FILL;
          err_q   <= 1'b0;
          cnt_q   <= '0;
          wear_q  <= (init_wear == '0) ? {WEAR_W{1'b1}} : init_wear;
        end
        LD_FILL: state_q <= LD_LIST;
        LD_LIST: if (take) begin
          if (is_end) begin
            state_q <= LD_IDLE;
          end else if (is_oob) begin
            state_q <= LD_IDLE;
            err_q   <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST_CNT) state_q <= LD_IDLE;
          end
        end
        default: state_q <= LD_IDLE;
      endcase
    end
  end

  // R6: an accepted start clears the error flag
  assert_err_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (init_start && !busy) |=> (!init_error && busy));
  // R5: the mark count never exceeds its limit
  assert_mark_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mark_en |-> (cnt_q < CNT_W'(MAX_BAD)));
  // R2: counters are loaded the cycle after an accepted start
  assert_fill_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (init_start && !busy) |=> load_en);
endmodule

// File: rtl/fbh_query.sv
module fbh_query #(
  parameter int NUM_BLOCKS = 16,
  parameter int BLK_W      = 8,
  localparam int BIDX_W    = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  busy,
  input  logic [NUM_BLOCKS-1:0] usable,
  input  logic                  q_valid,
  output logic                  q_ready,
  input  logic [BLK_W-1:0]      q_block,
  output logic                  rsp_valid,
  output logic                  rsp_ok
);
  localparam logic [BLK_W-1:0] NB_Q = BLK_W'(NUM_BLOCKS);

  logic in_range, accept;

  assign q_ready  = !busy;
  assign accept   = q_valid && q_ready;
  assign in_range = (q_block < NB_Q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
    end else begin
      rsp_valid <= accept;
      rsp_ok    <= accept && in_range && usable[q_block[BIDX_W-1:0]];
    end
  end

  // R7: one answer per accepted query, one cycle later
  assert_rsp_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);
  assert_rsp_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !rsp_valid);
  // R8: out-of-range queries are answered unusable
  assert_oob_invalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !in_range) |=> !rsp_ok);
endmodule

// File: rtl/flash_block_health.sv
module flash_block_health #(
  parameter int BLOCKS_PER_LUN = 8,
  parameter int NUM_LUNS       = 2,
  parameter int WEAR_W         = 8,
  parameter int BLK_W          = 8,
  parameter int MAX_BAD        = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_start,
  input  logic [WEAR_W-1:0] init_wear,
  input  logic              bb_valid,
  output logic              bb_ready,
  input  logic [31:0]       bb_index,
  output logic              busy,
  output logic              init_error,
  input  logic              q_valid,
  output logic              q_ready,
  input  logic [BLK_W-1:0]  q_block,
  output logic              rsp_valid,
  output logic              rsp_ok,
  input  logic              er_valid,
  output logic              er_ready,
  input  logic [BLK_W-1:0]  er_block
);
  localparam int NUM_BLOCKS = BLOCKS_PER_LUN * NUM_LUNS;
  localparam int BIDX_W     = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1;

  logic                  load_en, mark_en, er_take;
  logic [WEAR_W-1:0]     load_wear;
  logic [BIDX_W-1:0]     mark_idx;
  logic [NUM_BLOCKS-1:0] usable;

  fbh_loader #(
    .NUM_BLOCKS(NUM_BLOCKS), .WEAR_W(WEAR_W), .LIST_W(32), .MAX_BAD(MAX_BAD)
  ) u_loader (
    .clk(clk), .rst_n(rst_n), .init_start(init_start), .init_wear(init_wear),
    .bb_valid(bb_valid), .bb_ready(bb_ready), .bb_index(bb_index),
    .busy(busy), .init_error(init_error), .load_en(load_en),
    .load_wear(load_wear), .mark_en(mark_en), .mark_idx(mark_idx)
  );

  assign er_ready = !busy;
  assign er_take  = er_valid && er_ready;

  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_cell
    fbh_cell #(.WEAR_W(WEAR_W)) u_cell (
      .clk(clk), .rst_n(rst_n),
      .load_en(load_en), .load_wear(load_wear),
      .mark_en(mark_en && (mark_idx == BIDX_W'(g))),
      .erase_en(er_take && (er_block == BLK_W'(g))),
      .usable(usable[g])
    );
  end

  fbh_query #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W)) u_query (
    .clk(clk), .rst_n(rst_n), .busy(busy), .usable(usable),
    .q_valid(q_valid), .q_ready(q_ready), .q_block(q_block),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok)
  );

  // R7: neither side channel is accepted during initialisation
  assert_busy_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!q_ready && !er_ready));
  // R4: the list channel is only open during initialisation
  assert_list_in_init_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bb_ready |-> busy);
endmodule

// File: tb/test_flash_block_health.sv
`timescale 1ns/1ps
module test_flash_block_health;
  localparam int NB = 16;
  localparam int MAXB = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic init_start = 0, bb_valid = 0, q_valid = 0, er_valid = 0;
  logic [7:0] init_wear = 0, q_block = 0, er_block = 0;
  logic [31:0] bb_index = 0;
  logic bb_ready, busy, init_error, q_ready, rsp_valid, rsp_ok, er_ready;

  always #2.5 clk = ~clk;

  flash_block_health i_flash_block_health (
    .clk(clk), .rst_n(rst_n), .init_start(init_start), .init_wear(init_wear),
    .bb_valid(bb_valid), .bb_ready(bb_ready), .bb_index(bb_index),
    .busy(busy), .init_error(init_error), .q_valid(q_valid), .q_ready(q_ready),
    .q_block(q_block), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
    .er_valid(er_valid), .er_ready(er_ready), .er_block(er_block)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural reference model
  int m_wear[NB];
  bit m_bad[NB];
  int m_state = 0, m_cnt = 0, m_lim = 0;
  bit m_err = 0, m_rv = 0, m_rok = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_wear[i]) begin m_wear[i] = 0; m_bad[i] = 0; end
      m_state = 0; m_cnt = 0; m_err = 0; m_rv = 0; m_rok = 0; m_lim = 0;
    end else begin
      bit idle;
      idle  = (m_state == 0);
      m_rv  = q_valid && idle;
      m_rok = m_rv && (int'(q_block) < NB) && !m_bad[q_block] && m_wear[q_block] != 0;
      if (er_valid && idle && int'(er_block) < NB &&
          m_wear[er_block] != 0 && m_wear[er_block] != 255)
        m_wear[er_block] = m_wear[er_block] - 1;
      if (m_state == 0) begin
        if (init_start) begin
          m_state = 1; m_err = 0; m_cnt = 0;
          m_lim = (init_wear == 0) ? 255 : int'(init_wear);
        end
      end else if (m_state == 1) begin
        foreach (m_wear[i]) begin m_wear[i] = m_lim; m_bad[i] = 0; end
        m_state = 2;
      end else if (bb_valid) begin
        if (bb_index == 32'hFFFF_FFFF) m_state = 0;
        else if (bb_index >= NB) begin m_state = 0; m_err = 1; end
        else begin
          m_bad[bb_index] = 1; m_cnt++;
          if (m_cnt == MAXB) m_state = 0;
        end
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare against the model every cycle, away from the edge
  always @(negedge clk) if (rst_n && !done) begin
    chk("R2", "busy", busy, m_state != 0);
    chk("R4", "bb_ready", bb_ready, m_state == 2);
    chk("R7", "q_ready", q_ready, m_state == 0);
    chk("R7", "er_ready", er_ready, m_state == 0);
    chk("R7", "rsp_valid", rsp_valid, m_rv);
    chk("R7", "rsp_ok", rsp_ok, m_rok);
    chk("R6", "init_error", init_error, m_err);
  end

  task automatic query(int blk, bit exp, string req);
    @(negedge clk); q_valid = 1; q_block = 8'(blk);
    @(negedge clk); q_valid = 0;
    chk(req, $sformatf("rsp_valid blk %0d", blk), rsp_valid, 1);
    chk(req, $sformatf("rsp_ok blk %0d", blk), rsp_ok, exp);
  endtask

  task automatic erase(int blk, int times);
    for (int i = 0; i < times; i++) begin
      @(negedge clk); er_valid = 1; er_block = 8'(blk);
    end
    @(negedge clk); er_valid = 0;
  endtask

  task automatic run_init(int lim, int list[$]);
    @(negedge clk); init_start = 1; init_wear = 8'(lim);
    @(negedge clk); init_start = 0;
    chk("R7", "q_ready low during init", q_ready, 0);
    foreach (list[k]) begin
      while (!bb_ready && busy) @(negedge clk);
      if (!busy) break;
      bb_valid = 1; bb_index = list[k];
      @(negedge clk); bb_valid = 0;
    end
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "busy after reset", busy, 0);
    chk("R1", "init_error after reset", init_error, 0);
    chk("R1", "rsp_valid after reset", rsp_valid, 0);
    query(0, 0, "R1");
    // R4 list with sentinel, limit 2
    run_init(2, '{3, 9, 32'hFFFF_FFFF, 5});
    query(3, 0, "R4"); query(9, 0, "R4"); query(4, 1, "R2");
    query(5, 1, "R4");
    query(15, 1, "R10"); query(16, 0, "R10"); query(200, 0, "R8");
    // R9 wear-out and no wrap
    erase(4, 1); query(4, 1, "R9");
    erase(4, 1); query(4, 0, "R9");
    erase(4, 1); query(4, 0, "R9");
    erase(200, 1); query(7, 1, "R9");
    // R7 query on the same edge as an erase sees the old state
    @(negedge clk); er_valid = 1; er_block = 8'd6;
    @(negedge clk); er_block = 8'd6; q_valid = 1; q_block = 8'd6;
    @(negedge clk); er_valid = 0; q_valid = 0;
    chk("R7", "pre-erase answer", rsp_ok, 1);
    query(6, 0, "R9");
    // R2/R3 unlimited, bad flags cleared
    run_init(0, '{32'hFFFF_FFFF});
    query(3, 1, "R2");
    erase(5, 300); query(5, 1, "R3");
    // R5 mark limit
    run_init(1, '{0, 1, 2, 3, 7});
    chk("R5", "bb_ready after limit", bb_ready, 0);
    chk("R5", "busy after limit", busy, 0);
    query(3, 0, "R5"); query(7, 1, "R5");
    // R6 out-of-range entry
    run_init(5, '{5, 16, 6});
    chk("R6", "init_error set", init_error, 1);
    query(5, 0, "R6"); query(6, 1, "R6");
    run_init(5, '{32'hFFFF_FFFF});
    chk("R6", "init_error cleared", init_error, 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule